// File: doc/BRIEF.md
# DAC Sample Playback Sequencer

This block drives two 12-bit DAC channels from a 1024-entry sample queue. A scan starts on a rising edge of one selectable trigger source. Each scan writes one new word to each channel in the group, starting at channel 0. The group is either channel 0 alone or both channels. The last word written to a channel stays on its output until a later scan replaces it.

There are three operating styles. In streaming mode the host keeps topping up the queue. A level interrupt asks for more data once the queue is half empty or emptier. When streaming is set to non-continuous, a one-cycle pulse marks the moment the final sample leaves the queue. In wraparound mode each word sent to a DAC goes back into the tail of the queue, so a waveform loaded once plays forever, and host writes are locked out. In direct mode the queue is bypassed and each scan latches the values the host has placed on a separate pair of inputs.

Top module: `dac_playback`

## Requirements
- R1: After reset both DAC words are 0x000, and `irq_room`, `irq_empty` and `underrun` are low.
- R2: `cfg_trig_sel` picks the scan source: 0 timer tick, 1 external trigger, 2 counter-1 output, 3 parallel-port bit 0, 4 parallel-port bit 3. Codes 5 to 7 select nothing. A scan starts only when the selected source is high in a cycle after a cycle in which it was low. Other sources are ignored, and a source held high starts one scan only.
- R3: With `cfg_last_ch`=0 a scan updates channel 0 only. With `cfg_last_ch`=1, channel 0 updates at the clock edge that sees the trigger edge and channel 1 at the next edge. Trigger edges that arrive while a scan is in progress are ignored.
- R4: In streaming mode (`cfg_mode`=0), each channel slot takes the oldest queued word, in host write order. Channel 0 appears on `dac_out[11:0]` and channel 1 on `dac_out[23:12]`.
- R5: The queue holds at most 1024 words. A host write made while it is full is dropped.
- R6: In wraparound mode (`cfg_mode`=1) with `run` high, each word sent to a DAC is appended back to the queue, so the loaded sequence repeats with no host writes.
- R7: Host writes are ignored while `run` is high in wraparound mode.
- R8: `irq_room` is high exactly when `run` is high, the mode is streaming and the queue holds 512 words or fewer.
- R9: In non-continuous streaming (`cfg_continuous`=0), a slot that removes the last queued word, with no host write in the same cycle, raises `irq_empty` for exactly the following cycle.
- R10: A queue-fed slot that finds the queue empty leaves that DAC unchanged. In continuous streaming it also sets `underrun`, which stays high while `run` stays high.
- R11: In direct mode (`cfg_mode`=2), each slot latches `dir_data[12*ch +: 12]` for its channel, and the queue contents are left unchanged.
- R12: While `run` is low, or `cfg_mode`=3, no scan takes place and the DAC outputs hold. Driving `run` low clears `underrun`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Enables scanning |
| cfg_mode | input | 2 | 0 stream, 1 wraparound, 2 direct, 3 off |
| cfg_continuous | input | 1 | Streaming: 1 continuous, 0 ends when empty |
| cfg_last_ch | input | 1 | Index of last channel in the scan group |
| cfg_trig_sel | input | 3 | Scan trigger source code |
| trig_timer | input | 1 | Timer tick source |
| trig_ext | input | 1 | External trigger source |
| ctr1_out | input | 1 | Counter 1 output source |
| pport_c0 | input | 1 | Parallel-port bit 0 source |
| pport_c3 | input | 1 | Parallel-port bit 3 source |
| wr_valid | input | 1 | Host write strobe into the queue |
| wr_data | input | 12 | Host sample word |
| dir_data | input | 24 | Direct-mode words, channel 0 in the low 12 bits |
| dac_out | output | 24 | DAC words, channel 0 in the low 12 bits |
| irq_room | output | 1 | Queue half empty or emptier during streaming |
| irq_empty | output | 1 | One-cycle end-of-transfer pulse |
| underrun | output | 1 | Sticky starvation flag in continuous streaming |

## Verification
A trigger driven high after a falling edge changes channel 0 at the next rising edge and channel 1 one edge later. The bench therefore waits two full cycles after raising a source before comparing both words. For the sequencing check it also samples once in between, when only channel 0 should have moved. Host writes land on the edge after the strobe, and `irq_room` follows the fill level on that same edge. `irq_empty` is high during the cycle after the slot that drained the queue. Because every sample is taken at a falling edge, each of these results is seen exactly one half-cycle after it is due. A counter driven at falling edges records `irq_empty` pulses so their number can be compared with the model's count.

// File: rtl/dac_pb_pkg.sv
package dac_pb_pkg;

    typedef enum logic [1:0] {
        PB_STREAM = 2'd0,
        PB_WRAP   = 2'd1,
        PB_DIRECT = 2'd2,
        PB_OFF    = 2'd3
    } pb_mode_e;

    localparam int PB_TRIG_SRCS = 5;
    localparam int PB_TRIG_SELW = 3;

endpackage

// File: rtl/dac_trig_sel.sv
module dac_trig_sel #(
    parameter int NSRC = 5,
    parameter int SELW = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src,
    input  logic [SELW-1:0] sel,
    output logic            start
);

    typedef struct packed {
        logic [NSRC-1:0] prev;
    } trig_st_t;

    trig_st_t        s_q, s_d;
    logic [NSRC-1:0] rise_v;

    // one rising-edge detector per source
    for (genvar g = 0; g < NSRC; g++) begin : g_rise
        assign rise_v[g] = src[g] & ~s_q.prev[g];
    end

    always_comb begin
        s_d.prev = src;
        start    = 1'b0;
        for (int i = 0; i < NSRC; i++) begin
            if (sel == SELW'(i)) begin
                start = rise_v[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/dac_fifo.sv
module dac_fifo #(
    parameter  int DEPTH = 1024,
    parameter  int DW    = 12,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNTW  = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push,
    input  logic [DW-1:0]   push_data,
    input  logic            pop,
    output logic [DW-1:0]   head,
    output logic [CNTW-1:0] count
);

    typedef struct packed {
        logic [AW-1:0]   wr_ptr;
        logic [AW-1:0]   rd_ptr;
        logic [CNTW-1:0] count;
    } fifo_st_t;

    fifo_st_t      s_q, s_d;
    logic [DW-1:0] mem [DEPTH];
    logic          do_push;
    logic          do_pop;

    function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_comb begin
        s_d     = s_q;
        do_pop  = pop && (s_q.count != '0);
        do_push = push && ((s_q.count != CNTW'(DEPTH)) || do_pop);
        if (do_push) begin
            s_d.wr_ptr = ptr_next(s_q.wr_ptr);
        end
        if (do_pop) begin
            s_d.rd_ptr = ptr_next(s_q.rd_ptr);
        end
        case ({do_push, do_pop})
            2'b10:   s_d.count = s_q.count + CNTW'(1);
            2'b01:   s_d.count = s_q.count - CNTW'(1);
            default: s_d.count = s_q.count;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // storage carries no reset
    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[s_q.wr_ptr] <= push_data;
        end
    end

    assign head  = mem[s_q.rd_ptr];
    assign count = s_q.count;

endmodule

// File: rtl/dac_scan_seq.sv
module dac_scan_seq
    import dac_pb_pkg::*;
#(
    parameter  int NCH   = 2,
    parameter  int DW    = 12,
    parameter  int DEPTH = 1024,
    localparam int CHW   = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int CNTW  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  pb_mode_e          mode,
    input  logic              continuous,
    input  logic [CHW-1:0]    last_ch,
    input  logic              start,
    input  logic              push,
    input  logic [DW-1:0]     head,
    input  logic [CNTW-1:0]   count,
    input  logic [NCH*DW-1:0] dir_data,
    output logic              pop,
    output logic              slot_act,
    output logic              busy,
    output logic [NCH*DW-1:0] dac_out,
    output logic              irq_empty,
    output logic              underrun
);

    typedef struct packed {
        logic                   busy;
        logic [CHW-1:0]         ch;
        logic [NCH-1:0][DW-1:0] dac;
        logic                   irq_empty;
        logic                   underrun;
    } seq_st_t;

    seq_st_t        s_q, s_d;
    logic [CHW-1:0] cur;
    logic [CHW-1:0] last_eff;
    logic           fifo_has;

    assign cur      = s_q.busy ? s_q.ch : '0;
    assign last_eff = (int'(last_ch) > NCH - 1) ? CHW'(NCH - 1) : last_ch;
    assign fifo_has = (count != '0);
    assign slot_act = run && (mode != PB_OFF) && (s_q.busy || start);

    always_comb begin
        s_d           = s_q;
        s_d.busy      = 1'b0;
        s_d.irq_empty = 1'b0;
        pop           = 1'b0;
        if (slot_act) begin
            if (mode == PB_DIRECT) begin
                s_d.dac[cur] = dir_data[int'(cur)*DW +: DW];
            end else if (fifo_has) begin
                pop          = 1'b1;
                s_d.dac[cur] = head;
            end else if ((mode == PB_STREAM) && continuous) begin
                s_d.underrun = 1'b1;
            end
            s_d.busy = (cur < last_eff);
            s_d.ch   = cur + CHW'(1);
        end
        if (!run) begin
            s_d.underrun = 1'b0;
        end
        s_d.irq_empty = run && (mode == PB_STREAM) && !continuous && pop
                        && (count == CNTW'(1)) && !push;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy      = s_q.busy;
    assign dac_out   = s_q.dac;
    assign irq_empty = s_q.irq_empty;
    assign underrun  = s_q.underrun;

endmodule

// File: rtl/dac_playback.sv
module dac_playback
    import dac_pb_pkg::*;
#(
    parameter  int DEPTH = 1024,
    parameter  int DW    = 12,
    parameter  int NCH   = 2,
    localparam int CHW   = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int CNTW  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [1:0]        cfg_mode,
    input  logic              cfg_continuous,
    input  logic [CHW-1:0]    cfg_last_ch,
    input  logic [2:0]        cfg_trig_sel,
    input  logic              trig_timer,
    input  logic              trig_ext,
    input  logic              ctr1_out,
    input  logic              pport_c0,
    input  logic              pport_c3,
    input  logic              wr_valid,
    input  logic [DW-1:0]     wr_data,
    input  logic [NCH*DW-1:0] dir_data,
    output logic [NCH*DW-1:0] dac_out,
    output logic              irq_room,
    output logic              irq_empty,
    output logic              underrun
);

    pb_mode_e                mode;
    logic [PB_TRIG_SRCS-1:0] trig_src;
    logic                    start_evt;
    logic                    wrap_active;
    logic                    push;
    logic [DW-1:0]           push_data;
    logic                    pop;
    logic [DW-1:0]           fifo_head;
    logic [CNTW-1:0]         fifo_count;
    logic                    slot_act;
    logic                    busy;

    assign mode     = pb_mode_e'(cfg_mode);
    assign trig_src = {pport_c3, pport_c0, ctr1_out, trig_ext, trig_timer};

    dac_trig_sel #(
        .NSRC (PB_TRIG_SRCS),
        .SELW (PB_TRIG_SELW)
    ) u_trig (
        .clk   (clk),
        .rst_n (rst_n),
        .src   (trig_src),
        .sel   (cfg_trig_sel),
        .start (start_evt)
    );

    // recirculation replaces host writes during wraparound playback
    assign wrap_active = run && (mode == PB_WRAP);
    assign push        = wrap_active ? pop : (wr_valid && (fifo_count < CNTW'(DEPTH)));
    assign push_data   = wrap_active ? fifo_head : wr_data;

    dac_fifo #(
        .DEPTH (DEPTH),
        .DW    (DW)
    ) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_data (push_data),
        .pop       (pop),
        .head      (fifo_head),
        .count     (fifo_count)
    );

    dac_scan_seq #(
        .NCH   (NCH),
        .DW    (DW),
        .DEPTH (DEPTH)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .mode       (mode),
        .continuous (cfg_continuous),
        .last_ch    (cfg_last_ch),
        .start      (start_evt),
        .push       (push),
        .head       (fifo_head),
        .count      (fifo_count),
        .dir_data   (dir_data),
        .pop        (pop),
        .slot_act   (slot_act),
        .busy       (busy),
        .dac_out    (dac_out),
        .irq_empty  (irq_empty),
        .underrun   (underrun)
    );

    assign irq_room = run && (mode == PB_STREAM) && (fifo_count <= CNTW'(DEPTH / 2));

endmodule

// File: rtl/dac_playback_chk.sv
module dac_playback_chk #(
    parameter int DEPTH = 1024,
    parameter int DW    = 12,
    parameter int NCH   = 2,
    parameter int CNTW  = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              run,
    input logic [1:0]        cfg_mode,
    input logic              wr_valid,
    input logic [CNTW-1:0]   fifo_count,
    input logic [NCH*DW-1:0] dac_out,
    input logic              slot_act,
    input logic              busy,
    input logic              start_evt,
    input logic              irq_empty,
    input logic              underrun
);

    logic wrap_on;
    logic direct_on;

    assign wrap_on   = run && (cfg_mode == 2'd1);
    assign direct_on = run && (cfg_mode == 2'd2);

    AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_count <= CNTW'(DEPTH)); // R5

    AST_WRAP_LEVEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_on |=> $stable(fifo_count)); // R7

    AST_DIRECT_NO_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (direct_on && !wr_valid) |=> $stable(fifo_count)); // R11

    AST_DAC_ONLY_IN_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dac_out) |-> $past(slot_act)); // R3

    AST_SCAN_FROM_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start_evt)); // R3

    AST_EMPTY_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_empty |=> !irq_empty); // R9

    AST_EMPTY_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        irq_empty |-> (fifo_count == '0)); // R9

    AST_UNDERRUN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (underrun && run) |=> underrun); // R10

    AST_UNDERRUN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !underrun); // R12

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable(dac_out)); // R12

endmodule

bind dac_playback dac_playback_chk #(
    .DEPTH (DEPTH),
    .DW    (DW),
    .NCH   (NCH),
    .CNTW  (CNTW)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run),
    .cfg_mode   (cfg_mode),
    .wr_valid   (wr_valid),
    .fifo_count (fifo_count),
    .dac_out    (dac_out),
    .slot_act   (slot_act),
    .busy       (busy),
    .start_evt  (start_evt),
    .irq_empty  (irq_empty),
    .underrun   (underrun)
);

// File: tb/tb_dac_playback.sv
module tb_dac_playback;

    localparam int DEPTH = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic [1:0]  cfg_mode = 2'd0;
    logic        cfg_continuous = 1'b0;
    logic [0:0]  cfg_last_ch = 1'b0;
    logic [2:0]  cfg_trig_sel = 3'd0;
    logic [4:0]  srcv = '0;
    logic        wr_valid = 1'b0;
    logic [11:0] wr_data = '0;
    logic [23:0] dir_data = '0;
    logic [23:0] dac_out;
    logic        irq_room;
    logic        irq_empty;
    logic        underrun;

    always #2 clk = ~clk;

    dac_playback dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .run            (run),
        .cfg_mode       (cfg_mode),
        .cfg_continuous (cfg_continuous),
        .cfg_last_ch    (cfg_last_ch),
        .cfg_trig_sel   (cfg_trig_sel),
        .trig_timer     (srcv[0]),
        .trig_ext       (srcv[1]),
        .ctr1_out       (srcv[2]),
        .pport_c0       (srcv[3]),
        .pport_c3       (srcv[4]),
        .wr_valid       (wr_valid),
        .wr_data        (wr_data),
        .dir_data       (dir_data),
        .dac_out        (dac_out),
        .irq_room       (irq_room),
        .irq_empty      (irq_empty),
        .underrun       (underrun)
    );

    int          total = 0;
    int          bad = 0;
    int          q[$];
    logic [11:0] exp_dac [2];
    bit          exp_under = 1'b0;
    int          exp_pulses = 0;
    int          seen_pulses = 0;

    always @(negedge clk) begin
        if (rst_n && irq_empty) seen_pulses++;
    end

    task automatic check(bit ok, string req, string what, int act, int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    task automatic check_dacs(string req);
        check(dac_out[11:0] == exp_dac[0], req, "dac ch0", int'(dac_out[11:0]), int'(exp_dac[0]));
        check(dac_out[23:12] == exp_dac[1], req, "dac ch1", int'(dac_out[23:12]), int'(exp_dac[1]));
        check(underrun == exp_under, "R10", "underrun", int'(underrun), int'(exp_under));
    endtask

    // reference model of one scan, from the requirements
    function automatic void model_scan();
        if (!run || cfg_mode == 2'd3) return;
        for (int ch = 0; ch <= int'(cfg_last_ch); ch++) begin
            if (cfg_mode == 2'd2) begin
                exp_dac[ch] = dir_data[ch*12 +: 12];
            end else if (q.size() > 0) begin
                int v;
                v = q.pop_front();
                exp_dac[ch] = 12'(v);
                if (cfg_mode == 2'd1) q.push_back(v);
                if (cfg_mode == 2'd0 && !cfg_continuous && q.size() == 0) exp_pulses++;
            end else if (cfg_mode == 2'd0 && cfg_continuous) begin
                exp_under = 1'b1;
            end
        end
    endfunction

    task automatic pulse(int idx);
        @(negedge clk) srcv[idx] = 1'b1;
        @(negedge clk) srcv[idx] = 1'b0;
    endtask

    task automatic do_scan(string req);
        model_scan();
        pulse(int'(cfg_trig_sel));
        @(negedge clk);
        check_dacs(req);
    endtask

    task automatic host_write(logic [11:0] v);
        @(negedge clk) begin
            wr_valid = 1'b1;
            wr_data  = v;
        end
        @(negedge clk) wr_valid = 1'b0;
        if (!(run && cfg_mode == 2'd1) && q.size() < DEPTH) q.push_back(int'(v));
    endtask

    task automatic set_run(bit r);
        run = r;
        if (!r) exp_under = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog all: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int unsigned seed_use;
        int pbase;
        int ebase;
        logic [11:0] old1;
        seed_use = $urandom(32'd5150);
        exp_dac[0] = '0;
        exp_dac[1] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(dac_out == 24'h0, "R1", "dac after reset", int'(dac_out), 0);
        check(!irq_room && !irq_empty && !underrun, "R1", "flags after reset",
              int'({irq_room, irq_empty, underrun}), 0);

        // preload three words, then run direct mode (R11 keeps them)
        for (int i = 0; i < 3; i++) host_write(12'($urandom));

        set_run(1'b1);
        cfg_mode    = 2'd2;
        cfg_last_ch = 1'b1;
        for (int s = 0; s < 5; s++) begin
            cfg_trig_sel = 3'(s);
            dir_data     = 24'($urandom);
            do_scan("R2 R11");
        end
        check(irq_room == 1'b0, "R8", "room in direct mode", int'(irq_room), 0);

        // R2 unselected sources are ignored
        cfg_trig_sel = 3'd2;
        dir_data     = 24'($urandom);
        pulse(0);
        pulse(1);
        pulse(3);
        pulse(4);
        @(negedge clk);
        check_dacs("R2 unselected");

        // R2 code 5 selects nothing
        cfg_trig_sel = 3'd5;
        for (int s = 0; s < 5; s++) pulse(s);
        @(negedge clk);
        check_dacs("R2 no source");

        // R2 held-high source starts one scan only
        cfg_trig_sel = 3'd1;
        dir_data     = 24'($urandom);
        model_scan();
        @(negedge clk) srcv[1] = 1'b1;
        repeat (3) @(negedge clk);
        dir_data = ~dir_data;
        repeat (3) @(negedge clk);
        srcv[1] = 1'b0;
        @(negedge clk);
        check_dacs("R2 held");

        // R3 channel order within a scan
        cfg_trig_sel = 3'd0;
        dir_data     = ~dir_data ^ 24'h5A5A5A;
        old1         = exp_dac[1];
        model_scan();
        @(negedge clk) srcv[0] = 1'b1;
        @(negedge clk) srcv[0] = 1'b0;
        check(dac_out[11:0] == exp_dac[0], "R3", "ch0 first edge", int'(dac_out[11:0]), int'(exp_dac[0]));
        check(dac_out[23:12] == old1, "R3", "ch1 not yet", int'(dac_out[23:12]), int'(old1));
        @(negedge clk);
        check(dac_out[23:12] == exp_dac[1], "R3", "ch1 second edge", int'(dac_out[23:12]), int'(exp_dac[1]));

        // R3 single-channel group
        cfg_last_ch = 1'b0;
        dir_data    = 24'($urandom);
        do_scan("R3 one channel");

        // R12 mode off and run low
        cfg_mode = 2'd3;
        dir_data = 24'($urandom);
        pulse(0);
        @(negedge clk);
        check_dacs("R12 mode off");
        cfg_mode = 2'd2;
        set_run(1'b0);
        pulse(0);
        @(negedge clk);
        check_dacs("R12 run low");

        // R4 streaming the preloaded words, R10 starvation
        cfg_mode       = 2'd0;
        cfg_continuous = 1'b1;
        cfg_last_ch    = 1'b1;
        set_run(1'b1);
        @(negedge clk);
        check(irq_room == 1'b1, "R8", "room with 3 queued", int'(irq_room), 1);
        do_scan("R4");
        do_scan("R10 starve ch1");
        host_write(12'hABC);
        do_scan("R10 hold flag");
        set_run(1'b0);
        @(negedge clk);
        check_dacs("R12 clear underrun");

        // R8 threshold at half depth
        set_run(1'b1);
        for (int i = 0; i < DEPTH / 2; i++) host_write(12'($urandom));
        check(irq_room == 1'b1, "R8", "room at 512", int'(irq_room), 1);
        host_write(12'($urandom));
        check(irq_room == 1'b0, "R8", "room at 513", int'(irq_room), 0);

        // random streaming mix
        for (int it = 0; it < 400; it++) begin
            if ($urandom % 4 == 0) begin
                host_write(12'($urandom));
            end else begin
                cfg_last_ch = 1'($urandom % 2);
                do_scan("R4 random");
            end
            check(irq_room == (q.size() <= DEPTH / 2), "R8", "room level",
                  int'(irq_room), int'(q.size() <= DEPTH / 2));
        end
        cfg_last_ch = 1'b1;
        while (q.size() > 0) do_scan("R4 drain");

        // R5 overfill, then R9 end-of-transfer pulse
        set_run(1'b0);
        @(negedge clk);
        for (int i = 0; i < DEPTH + 2; i++) host_write(12'(i + 1));
        cfg_continuous = 1'b0;
        set_run(1'b1);
        @(negedge clk);
        check(irq_room == 1'b0, "R8", "room when full", int'(irq_room), 0);
        pbase = seen_pulses;
        ebase = exp_pulses;
        for (int i = 0; i < DEPTH / 2; i++) do_scan("R5");
        do_scan("R5 dropped words absent");
        check(seen_pulses - pbase == exp_pulses - ebase, "R9", "empty pulses",
              seen_pulses - pbase, exp_pulses - ebase);

        // R6 wraparound playback, R7 host writes locked out
        set_run(1'b0);
        cfg_mode = 2'd1;
        @(negedge clk);
        for (int i = 0; i < 5; i++) host_write(12'($urandom));
        set_run(1'b1);
        for (int it = 0; it < 12; it++) begin
            if (it % 3 == 2) begin
                host_write(12'($urandom));
                do_scan("R7");
            end else begin
                do_scan("R6");
            end
        end
        cfg_last_ch = 1'b0;
        for (int it = 0; it < 4; it++) do_scan("R6 one channel");
        check(irq_room == 1'b0, "R8", "room in wrap mode", int'(irq_room), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule